// File: doc/BRIEF.md
# Serial Port Status and Interrupt Request Unit

This unit keeps the status flags and interrupt enables of a byte-wide serial port and turns them into three interrupt requests: transmit buffer empty, receive buffer full and receive error (overrun). The processor reaches it through a small register interface with an address, a read strobe, a write strobe and a data byte. The serial datapath reports two events as single-cycle strobes. One says that the transmit byte has moved into the shifter. The other says that a received byte is ready to move into the receive register. The unit holds the transmit byte and the receive byte.

Status flags follow a read-then-clear rule. A flag can be cleared by writing 0 to its bit only after the processor has read the status register while that flag was 1. Writing 1 never sets a flag. One receive enable gates both the receive-full request and the error request.

Top module: `serial_irq_flags`

Register addresses: 0 is control, 1 is status, 2 is transmit byte (write), 3 is receive byte (read).

## Requirements
- R1: After reset, the control register reads 0x00, status reads 0x80 (transmit-empty set, receive-full and overrun clear), and all three interrupt requests are 0.
- R2: The control register at address 0 holds the transmit interrupt enable in bit 7 and the receive interrupt enable in bit 6. Both can be written and read back. Its other bits read as 0.
- R3: The status register at address 1 shows transmit-empty in bit 7, receive-full in bit 6 and overrun in bit 5. Its other bits read as 0.
- R4: A transmit-load strobe sets transmit-empty. A write to address 2 stores the byte on tx_byte_o and clears transmit-empty on the same edge.
- R5: A receive-load strobe while receive-full is 0 sets receive-full and captures rx_byte_i into the receive register, which reads back at address 3.
- R6: A receive-load strobe while receive-full is 1 sets overrun. The receive register keeps its old byte.
- R7: A status write with 0 in a flag's bit clears that flag only if a status read has seen the flag as 1 since the flag was last cleared. Without such a read, the flag stays unchanged. A successful clear, or a clear overridden by a hardware set, uses up that read.
- R8: Writing 1 to a status bit never sets the flag.
- R9: When a hardware set and a clear of the same flag happen in the same cycle, the flag ends at 1.
- R10: tx_irq_o equals transmit enable AND transmit-empty. rx_irq_o equals receive enable AND receive-full. err_irq_o equals receive enable AND overrun. Clearing the enable or the flag removes the request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| rd_en_i | input | 1 | Read strobe (arms flag clears on a status read) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tx_load_i | input | 1 | Transmit byte moved into the shifter |
| rx_load_i | input | 1 | Received byte ready for the receive register |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Stored transmit byte |
| tx_irq_o | output | 1 | Transmit-empty request |
| rx_irq_o | output | 1 | Receive-full request |
| err_irq_o | output | 1 | Receive-error request |

## Verification
The assertions check some rules on every cycle:
- a flag with no read armed survives a clear write (R7);
- a hardware set always leaves the flag at 1, and a flag rises only on a hardware set (R8, R9);
- overrun rises only over a full receive register, and that register then stays stable (R6);
- no request is present without its enable (R10).

The bench scenarios cover what the assertions cannot show:
- the register layouts and reset values;
- the full sweep of control and status write values;
- the read-then-clear sequence with an exact readback;
- the request pattern for each combination of enables.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int FLAG_N = 3;

    // flag index: 0 = transmit empty, 1 = receive full, 2 = overrun
    localparam int F_TXE = 0;
    localparam int F_RXF = 1;
    localparam int F_OVR = 2;

    localparam int CTRL_TIE_BIT = 7;
    localparam int CTRL_RIE_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_addr_e;

    function automatic int stat_bit(input int idx);
        return 7 - idx;
    endfunction

    typedef struct packed {
        logic              tie;
        logic              rie;
        logic [DATA_W-1:0] txd;
        logic [DATA_W-1:0] rxd;
    } core_state_t;
endpackage

// File: rtl/sif_flag.sv
module sif_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic hw_clr_i,
    input  logic sw_read_i,
    input  logic sw_clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic        clr_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = (sw_clr_i && st_q.armed) || hw_clr_i;
        if (clr_hit) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (sw_read_i && st_q.flag && !clr_hit) begin
            st_d.armed = 1'b1;
        end
        if (hw_set_i) begin
            st_d.flag = 1'b1;
        end
        if (!st_d.flag) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag  <= RST_VAL;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_unarmed_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && sw_clr_i && !st_q.armed && !hw_clr_i) |=> st_q.flag);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i |=> st_q.flag);

    assert_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.flag && !hw_set_i) |=> !st_q.flag);
endmodule

// File: rtl/sif_irq.sv
module sif_irq (
    input  logic tie_i,
    input  logic rie_i,
    input  logic txe_i,
    input  logic rxf_i,
    input  logic ovr_i,
    output logic tx_irq_o,
    output logic rx_irq_o,
    output logic err_irq_o
);
    always_comb begin
        tx_irq_o  = tie_i && txe_i;
        rx_irq_o  = rie_i && rxf_i;
        err_irq_o = rie_i && ovr_i;
    end
endmodule

// File: rtl/serial_irq_flags.sv
module serial_irq_flags
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tx_load_i,
    input  logic              rx_load_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              tx_irq_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    core_state_t       cs_d, cs_q;
    logic [FLAG_N-1:0] flags;
    logic [FLAG_N-1:0] hw_set;
    logic [FLAG_N-1:0] hw_clr;
    logic [FLAG_N-1:0] sw_clr;
    logic              stat_rd;
    logic              stat_wr;
    logic              rxd_take;

    always_comb begin
        stat_rd  = rd_en_i && (addr_i == REG_STAT);
        stat_wr  = wr_en_i && (addr_i == REG_STAT);
        rxd_take = rx_load_i && !flags[F_RXF];

        hw_set         = '0;
        hw_set[F_TXE]  = tx_load_i;
        hw_set[F_RXF]  = rx_load_i;
        hw_set[F_OVR]  = rx_load_i && flags[F_RXF];

        hw_clr         = '0;
        hw_clr[F_TXE]  = wr_en_i && (addr_i == REG_TXD);

        for (int i = 0; i < FLAG_N; i++) begin
            sw_clr[i] = stat_wr && !wdata_i[stat_bit(i)];
        end
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        sif_flag #(.RST_VAL(g == F_TXE)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_set_i (hw_set[g]),
            .hw_clr_i (hw_clr[g]),
            .sw_read_i(stat_rd),
            .sw_clr_i (sw_clr[g]),
            .flag_o   (flags[g])
        );
    end

    always_comb begin
        cs_d = cs_q;
        if (wr_en_i && (addr_i == REG_CTRL)) begin
            cs_d.tie = wdata_i[CTRL_TIE_BIT];
            cs_d.rie = wdata_i[CTRL_RIE_BIT];
        end
        if (wr_en_i && (addr_i == REG_TXD)) begin
            cs_d.txd = wdata_i;
        end
        if (rxd_take) begin
            cs_d.rxd = rx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            REG_CTRL: begin
                rdata_o[CTRL_TIE_BIT] = cs_q.tie;
                rdata_o[CTRL_RIE_BIT] = cs_q.rie;
            end
            REG_STAT: begin
                for (int i = 0; i < FLAG_N; i++) begin
                    rdata_o[stat_bit(i)] = flags[i];
                end
            end
            REG_TXD: rdata_o = cs_q.txd;
            REG_RXD: rdata_o = cs_q.rxd;
            default: rdata_o = '0;
        endcase
    end

    assign tx_byte_o = cs_q.txd;

    sif_irq u_irq (
        .tie_i    (cs_q.tie),
        .rie_i    (cs_q.rie),
        .txe_i    (flags[F_TXE]),
        .rxf_i    (flags[F_RXF]),
        .ovr_i    (flags[F_OVR]),
        .tx_irq_o (tx_irq_o),
        .rx_irq_o (rx_irq_o),
        .err_irq_o(err_irq_o)
    );

    assert_ovr_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_OVR]) |-> $past(flags[F_RXF]));

    assert_rxd_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && flags[F_RXF]) |=> $stable(cs_q.rxd));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_irq_o |-> cs_q.tie) and ((rx_irq_o || err_irq_o) |-> cs_q.rie)));
endmodule

// File: tb/sim_serial_irq_flags.sv
module sim_serial_irq_flags;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_load = 1'b0;
    logic       rx_load = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] tx_byte;
    logic       tx_irq, rx_irq, err_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .wdata_i(wdata), .rdata_o(rdata), .tx_load_i(tx_load), .rx_load_i(rx_load),
        .rx_byte_i(rx_byte), .tx_byte_o(tx_byte), .tx_irq_o(tx_irq),
        .rx_irq_o(rx_irq), .err_irq_o(err_irq)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] b);
        @(negedge clk); rx_load = 1'b1; rx_byte = b;
        @(negedge clk); rx_load = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic [2:0] exp);
        #1 check(req, "irq {tx,rx,err}", {5'd0, tx_irq, rx_irq, err_irq}, {5'd0, exp});
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd0, v); check("R1", "ctrl after reset", v, 8'h00);
        peek(2'd1, v); check("R1", "status after reset", v, 8'h80);
        irq_chk("R1", 3'b000);

        // R2 control register sweep
        for (int i = 0; i < 256; i++) begin
            wr(2'd0, 8'(i));
            peek(2'd0, v);
            check("R2", "ctrl readback", v, 8'(i) & 8'hC0);
        end
        wr(2'd0, 8'h00);

        // R7/R8 status writes without a prior read change nothing
        for (int i = 0; i < 256; i += 5) begin
            wr(2'd1, 8'(i));
            peek(2'd1, v);
            check("R7", "unarmed status write", v, 8'h80);
        end

        // R4 transmit byte write clears empty flag; load sets it
        wr(2'd2, 8'h5A);
        check("R4", "tx byte", tx_byte, 8'h5A);
        peek(2'd1, v); check("R4", "status after tx write", v, 8'h00);
        pulse_tx();
        peek(2'd1, v); check("R4", "status after tx load", v, 8'h80);

        // R5 receive load into empty register
        pulse_rx(8'h3C);
        peek(2'd1, v); check("R5", "status after rx load", v, 8'hC0);
        peek(2'd3, v); check("R5", "rx byte", v, 8'h3C);

        // R6 overrun keeps old byte; R3 layout
        pulse_rx(8'h99);
        peek(2'd1, v); check("R3", "status all flags", v, 8'hE0);
        peek(2'd3, v); check("R6", "rx byte kept on overrun", v, 8'h3C);

        // R10 request sweep over enables with all flags set
        for (int e = 0; e < 4; e++) begin
            wr(2'd0, {e[1], e[0], 6'd0});
            irq_chk("R10", {e[1], e[0], e[0]});
        end

        // R7 clear without read fails, with read succeeds
        wr(2'd1, 8'h00);
        peek(2'd1, v); check("R7", "clear without read", v, 8'hE0);
        rd(2'd1, v); check("R3", "status read", v, 8'hE0);
        wr(2'd1, 8'h00);
        peek(2'd1, v); check("R7", "clear after read", v, 8'h00);
        irq_chk("R10", 3'b000);

        // R8 write 1 to cleared flags does not set them
        wr(2'd1, 8'hFF);
        peek(2'd1, v); check("R8", "write ones", v, 8'h00);

        // R10 enable removal drops request
        pulse_tx();
        irq_chk("R10", 3'b100);
        wr(2'd0, 8'h40);
        irq_chk("R10", 3'b000);

        // R7 selective clear; R5 new byte after clear
        pulse_rx(8'h11);
        peek(2'd3, v); check("R5", "rx byte after clear", v, 8'h11);
        irq_chk("R10", 3'b010);
        rd(2'd1, v); check("R3", "status read", v, 8'hC0);
        wr(2'd1, 8'h80);
        peek(2'd1, v); check("R7", "selective clear", v, 8'h80);
        irq_chk("R10", 3'b000);

        // R9 set wins over armed clear, read used up
        rd(2'd1, v);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h00; wr_en = 1'b1; tx_load = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tx_load = 1'b0;
        peek(2'd1, v); check("R9", "set wins", v, 8'h80);
        wr(2'd1, 8'h00);
        peek(2'd1, v); check("R7", "read consumed by lost clear", v, 8'h80);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule